// File: doc/BRIEF.md
# Command Write Pacing and Status Flag Release

This block sits in front of a controller's command register. It decides, write by write, whether a command may pass. It also owns two status flags: "transmitter available" (TA) and "receiver inhibited" (RI). An accepted write comes out as a one-cycle strobe that carries its opcode. A write that comes too early is dropped, and a sticky flag records that a write was lost.

Two timing rules apply. The first is pacing: after an accepted command, further writes are held off for a fixed number of ticks of a timing base. The second is a prohibition window: when TA or RI returns high, the enable-transmit and enable-receive commands are refused for a fixed number of node-clock ticks. The node clock runs at eight times the data rate, so both rules stretch at low rates.

One fix-enable input changes both rules. It moves the pacing base to the fixed crystal tick. It also makes a flag rise at the end of its set pulse instead of the start, which removes the prohibition window. With the window gone, interrupt software may issue the next enable command at once.

Both clocks arrive as single-cycle tick enables in the block's own clock domain.

Top module: `cmd_pace_guard`

## Requirements
- R1: Out of reset, TA and RI are 1, the accept strobe is 0 and the rejected flag is 0.
- R2: An accepted write raises `cmd_accept` for exactly one cycle, the cycle after the write. During that cycle `cmd_accept_op` holds the written opcode.
- R3: After an accepted write, every further write is rejected until PACE_TICKS ticks of the selected timing base have been seen (default 2).
- R4: A rejected write produces no accept strobe and does not restart the pacing count. From the cycle after the write, `wr_rejected` reads 1 and stays 1 until reset.
- R5: With `fix_en` = 0 the pacing base is `node_tick`, and `xtal_tick` has no effect on pacing.
- R6: With `fix_en` = 1 the pacing base is `xtal_tick`, and `node_tick` has no effect on pacing.
- R7: An accepted enable-transmit (opcode ETX_OP, default 8'h03) clears TA, and an accepted enable-receive (ERX_OP, default 8'h04) clears RI. The flag reads 0 from the cycle after the write.
- R8: With `fix_en` = 0, a flag reads 1 from the cycle after its set pulse is first seen high.
- R9: With `fix_en` = 0, a rise of TA or RI opens a window of PROHIBIT_TICKS `node_tick` ticks (default 4). Inside the window, ETX_OP and ERX_OP writes are rejected and other opcodes are unaffected.
- R10: With `fix_en` = 1, a flag stays 0 while its set pulse is high and reads 1 from the cycle after the pulse goes low. No prohibition window follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fix_en | input | 1 | Selects crystal pacing and release of the flag at the end of its pulse |
| node_tick | input | 1 | One-cycle tick of the rate-dependent node clock |
| xtal_tick | input | 1 | One-cycle tick of the fixed crystal clock |
| cmd_wr | input | 1 | Command write strobe, one write per high cycle |
| cmd_op | input | OP_W | Opcode of the write |
| ta_set | input | 1 | Set pulse for TA |
| ri_set | input | 1 | Set pulse for RI |
| cmd_accept | output | 1 | One-cycle strobe for an accepted command |
| cmd_accept_op | output | OP_W | Opcode of the accepted command |
| ta | output | 1 | Transmitter-available flag |
| ri | output | 1 | Receiver-inhibited flag |
| wr_rejected | output | 1 | Sticky flag: a write was dropped |

## Verification
The bench builds the block with its defaults: an 8-bit opcode, PACE_TICKS = 2 and PROHIBIT_TICKS = 4. The bench issues every tick by hand, so it can place each write on a known count. It probes the pacing count one tick before expiry and the window count one tick before expiry. It also shows that a tick of the unselected clock leaves both counts untouched. The small counts keep the two windows overlapping, so the bench can check that an ordinary opcode passes inside the window while enable commands do not.

// File: rtl/cmdpace_pkg.sv
// Package: shared constants and types for the command pacing block.
// Assumes two status flags, indexed as below.
package cmdpace_pkg;
    localparam int unsigned FLAG_N  = 2;
    localparam int unsigned FLAG_TA = 0;
    localparam int unsigned FLAG_RI = 1;

    // Verdict on a single command write cycle.
    typedef enum logic [1:0] {
        ADM_IDLE   = 2'd0,
        ADM_ACCEPT = 2'd1,
        ADM_REJECT = 2'd2
    } admit_e;
endpackage

// File: rtl/cmdpace_countdown.sv
// Module: loadable down-counter timed by a tick enable.
// It loads LOAD on `load`, steps down by one on each `tick` while nonzero,
// and reports `busy` while nonzero. A load wins over a tick in the same
// cycle. Assumes LOAD >= 1.
module cmdpace_countdown #(
    parameter int unsigned LOAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic busy
);
    localparam int unsigned CW = (LOAD < 2) ? 1 : $clog2(LOAD + 1);

    logic [CW-1:0] cnt_q;

    // Count register: load, step down on a tick, hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(LOAD);
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Busy while any ticks remain.
    always_comb begin
        busy = (cnt_q != '0);
    end
endmodule

// File: rtl/cmdpace_flag_cell.sv
// Module: one status flag with its set-pulse edge detector.
// With fix_en low the flag sets on the first high cycle of the pulse. With
// fix_en high it sets on the first low cycle after the pulse. A set wins
// over a clear in the same cycle. `rise` marks a cycle in which the flag
// goes from 0 to 1 at the coming edge. The flag resets to 1.
module cmdpace_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic fix_en,
    input  logic set_pulse,
    input  logic clr,
    output logic flag,
    output logic rise
);
    logic pulse_q;
    logic start_evt;
    logic stop_evt;
    logic set_evt;

    // Previous pulse level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= set_pulse;
        end
    end

    // Pick the pulse edge that sets the flag.
    always_comb begin
        start_evt = set_pulse && !pulse_q;
        stop_evt  = !set_pulse && pulse_q;
        set_evt   = fix_en ? stop_evt : start_evt;
        rise      = set_evt && !flag;
    end

    // Flag register: a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b1;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cmdpace_admit.sv
// Module: combinational verdict for a command write.
// A write is rejected while pacing is busy. An enable-transmit or
// enable-receive write is also rejected while the prohibition window is
// open. Accepted enable writes request a clear of their flag.
module cmdpace_admit
    import cmdpace_pkg::*;
#(
    parameter int unsigned       OP_W   = 8,
    parameter logic [OP_W-1:0]   ETX_OP = 8'h03,
    parameter logic [OP_W-1:0]   ERX_OP = 8'h04
) (
    input  logic              cmd_wr,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic              pace_busy,
    input  logic              win_busy,
    output admit_e            verdict,
    output logic [FLAG_N-1:0] clr_req
);
    logic is_etx;
    logic is_erx;
    logic blocked;

    // Opcode class and the blocking decision.
    always_comb begin
        is_etx  = (cmd_op == ETX_OP);
        is_erx  = (cmd_op == ERX_OP);
        blocked = pace_busy || (win_busy && (is_etx || is_erx));
    end

    // Verdict and flag clear requests.
    always_comb begin
        clr_req = '0;
        if (!cmd_wr) begin
            verdict = ADM_IDLE;
        end else if (blocked) begin
            verdict = ADM_REJECT;
        end else begin
            verdict = ADM_ACCEPT;
            clr_req[FLAG_TA] = is_etx;
            clr_req[FLAG_RI] = is_erx;
        end
    end
endmodule

// File: rtl/cmd_pace_guard.sv
// Module: command write pacing and TA/RI status flag control (top).
// Paces command writes on a tick base chosen by fix_en, guards the enable
// commands with a window after a flag rise (fix_en low only), and drives the
// two flags. Both clocks arrive as tick enables in the clk domain.
// Outputs are registered.
module cmd_pace_guard
    import cmdpace_pkg::*;
#(
    parameter int unsigned       OP_W           = 8,
    parameter int unsigned       PACE_TICKS     = 2,
    parameter int unsigned       PROHIBIT_TICKS = 4,
    parameter logic [OP_W-1:0]   ETX_OP         = 8'h03,
    parameter logic [OP_W-1:0]   ERX_OP         = 8'h04
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fix_en,
    input  logic            node_tick,
    input  logic            xtal_tick,
    input  logic            cmd_wr,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            ta_set,
    input  logic            ri_set,
    output logic            cmd_accept,
    output logic [OP_W-1:0] cmd_accept_op,
    output logic            ta,
    output logic            ri,
    output logic            wr_rejected
);
    logic              pace_tick;
    logic              pace_busy;
    logic              win_load;
    logic              win_busy_raw;
    logic              win_busy;
    admit_e            verdict;
    logic [FLAG_N-1:0] clr_req;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] flag_vec;
    logic [FLAG_N-1:0] rise_vec;

    // Timing base select and window gating.
    always_comb begin
        pace_tick = fix_en ? xtal_tick : node_tick;
        win_load  = (|rise_vec) && !fix_en;
        win_busy  = win_busy_raw && !fix_en;
        set_vec[FLAG_TA] = ta_set;
        set_vec[FLAG_RI] = ri_set;
    end

    cmdpace_countdown #(.LOAD(PACE_TICKS)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (verdict == ADM_ACCEPT),
        .tick  (pace_tick),
        .busy  (pace_busy)
    );

    cmdpace_countdown #(.LOAD(PROHIBIT_TICKS)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (win_load),
        .tick  (node_tick),
        .busy  (win_busy_raw)
    );

    cmdpace_admit #(.OP_W(OP_W), .ETX_OP(ETX_OP), .ERX_OP(ERX_OP)) u_admit (
        .cmd_wr    (cmd_wr),
        .cmd_op    (cmd_op),
        .pace_busy (pace_busy),
        .win_busy  (win_busy),
        .verdict   (verdict),
        .clr_req   (clr_req)
    );

    // One flag cell per status flag.
    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        cmdpace_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .fix_en    (fix_en),
            .set_pulse (set_vec[g]),
            .clr       (clr_req[g]),
            .flag      (flag_vec[g]),
            .rise      (rise_vec[g])
        );
    end

    // Flag outputs.
    always_comb begin
        ta = flag_vec[FLAG_TA];
        ri = flag_vec[FLAG_RI];
    end

    // Accept strobe and opcode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_accept    <= 1'b0;
            cmd_accept_op <= '0;
        end else begin
            cmd_accept <= (verdict == ADM_ACCEPT);
            if (verdict == ADM_ACCEPT) begin
                cmd_accept_op <= cmd_op;
            end
        end
    end

    // Sticky rejected-write flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_rejected <= 1'b0;
        end else if (verdict == ADM_REJECT) begin
            wr_rejected <= 1'b1;
        end
    end
endmodule

// File: rtl/cmd_pace_guard_chk.sv
// Module: assertion checker for cmd_pace_guard, attached by bind.
// Observes only the top-level ports.
module cmd_pace_guard_chk #(
    parameter int unsigned     OP_W   = 8,
    parameter logic [OP_W-1:0] ETX_OP = 8'h03,
    parameter logic [OP_W-1:0] ERX_OP = 8'h04
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fix_en,
    input logic            cmd_wr,
    input logic [OP_W-1:0] cmd_op,
    input logic            ta_set,
    input logic            ri_set,
    input logic            cmd_accept,
    input logic [OP_W-1:0] cmd_accept_op,
    input logic            ta,
    input logic            ri,
    input logic            wr_rejected
);
    a_r2_accept_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> ($past(cmd_wr) && (cmd_accept_op == $past(cmd_op))));

    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> !cmd_accept);

    a_r4_reject_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rejected |=> wr_rejected);

    a_r7_ta_clear_by_etx: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ta) |-> ($past(cmd_wr) && ($past(cmd_op) == ETX_OP)));

    a_r7_ri_clear_by_erx: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ri) |-> ($past(cmd_wr) && ($past(cmd_op) == ERX_OP)));

    a_r8_ta_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ta) && !$past(fix_en)) |-> $past(ta_set));

    a_r10_ri_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ri) && $past(fix_en)) |-> !$past(ri_set));

    a_r10_ta_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ta) && $past(fix_en)) |-> !$past(ta_set));
endmodule

bind cmd_pace_guard cmd_pace_guard_chk #(
    .OP_W   (OP_W),
    .ETX_OP (ETX_OP),
    .ERX_OP (ERX_OP)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fix_en        (fix_en),
    .cmd_wr        (cmd_wr),
    .cmd_op        (cmd_op),
    .ta_set        (ta_set),
    .ri_set        (ri_set),
    .cmd_accept    (cmd_accept),
    .cmd_accept_op (cmd_accept_op),
    .ta            (ta),
    .ri            (ri),
    .wr_rejected   (wr_rejected)
);

// File: tb/cmd_pace_guard_tb.sv
module cmd_pace_guard_tb;
    localparam int unsigned OP_W = 8;
    localparam logic [7:0]  ETX  = 8'h03;
    localparam logic [7:0]  ERX  = 8'h04;
    localparam logic [7:0]  NOP  = 8'h01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fix_en = 1'b0;
    logic       node_tick = 1'b0;
    logic       xtal_tick = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_op = 8'h00;
    logic       ta_set = 1'b0;
    logic       ri_set = 1'b0;
    logic       cmd_accept;
    logic [7:0] cmd_accept_op;
    logic       ta;
    logic       ri;
    logic       wr_rejected;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cmd_pace_guard u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fix_en        (fix_en),
        .node_tick     (node_tick),
        .xtal_tick     (xtal_tick),
        .cmd_wr        (cmd_wr),
        .cmd_op        (cmd_op),
        .ta_set        (ta_set),
        .ri_set        (ri_set),
        .cmd_accept    (cmd_accept),
        .cmd_accept_op (cmd_accept_op),
        .ta            (ta),
        .ri            (ri),
        .wr_rejected   (wr_rejected)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One write; outputs are sampled at the next falling edge.
    task automatic do_write(input logic [7:0] op);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_op = op;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic do_tick(input logic nd, input logic xt);
        @(negedge clk);
        node_tick = nd;
        xtal_tick = xt;
        @(negedge clk);
        node_tick = 1'b0;
        xtal_tick = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ta", int'(ta), 1);
        chk("R1", "ri", int'(ri), 1);
        chk("R1", "accept", int'(cmd_accept), 0);
        chk("R1", "rejected", int'(wr_rejected), 0);
    endtask

    task automatic t_pace_node();
        fix_en = 1'b0;
        do_write(8'h5A);
        chk("R2", "accept", int'(cmd_accept), 1);
        chk("R2", "accept_op", int'(cmd_accept_op), 'h5A);
        @(negedge clk);
        chk("R2", "accept one cycle", int'(cmd_accept), 0);
        do_write(NOP);
        chk("R3", "write at once rejected", int'(cmd_accept), 0);
        chk("R4", "rejected flag", int'(wr_rejected), 1);
        do_tick(1'b1, 1'b0);
        do_write(NOP);
        chk("R3", "rejected one tick before expiry", int'(cmd_accept), 0);
        do_tick(1'b0, 1'b1);
        do_write(NOP);
        chk("R5", "crystal tick ignored", int'(cmd_accept), 0);
        do_tick(1'b1, 1'b0);
        do_write(8'h22);
        chk("R4", "reject did not restart pacing", int'(cmd_accept), 1);
        chk("R4", "rejected still sticky", int'(wr_rejected), 1);
    endtask

    task automatic t_pace_xtal();
        fix_en = 1'b1;
        do_tick(1'b0, 1'b1);
        do_tick(1'b0, 1'b1);
        do_write(8'h11);
        chk("R6", "accept", int'(cmd_accept), 1);
        do_tick(1'b1, 1'b0);
        do_tick(1'b1, 1'b0);
        do_write(NOP);
        chk("R6", "node ticks ignored", int'(cmd_accept), 0);
        do_tick(1'b0, 1'b1);
        do_tick(1'b0, 1'b1);
        do_write(8'h12);
        chk("R6", "accept after crystal ticks", int'(cmd_accept), 1);
        do_tick(1'b0, 1'b1);
        do_tick(1'b0, 1'b1);
    endtask

    task automatic t_clear_flags();
        fix_en = 1'b0;
        do_write(ETX);
        chk("R7", "ta cleared", int'(ta), 0);
        chk("R7", "ri untouched", int'(ri), 1);
        do_tick(1'b1, 1'b0);
        do_tick(1'b1, 1'b0);
        do_write(ERX);
        chk("R7", "ri cleared", int'(ri), 0);
        do_tick(1'b1, 1'b0);
        do_tick(1'b1, 1'b0);
    endtask

    task automatic t_window();
        fix_en = 1'b0;
        @(negedge clk);
        ta_set = 1'b1;
        @(negedge clk);
        chk("R8", "ta high after pulse start", int'(ta), 1);
        @(negedge clk);
        @(negedge clk);
        ta_set = 1'b0;
        do_write(ETX);
        chk("R9", "ETX rejected in window", int'(cmd_accept), 0);
        do_write(ERX);
        chk("R9", "ERX rejected in window", int'(cmd_accept), 0);
        do_write(NOP);
        chk("R9", "other opcode passes", int'(cmd_accept), 1);
        do_tick(1'b1, 1'b0);
        do_tick(1'b1, 1'b0);
        do_tick(1'b1, 1'b0);
        do_write(ETX);
        chk("R9", "ETX rejected one tick before end", int'(cmd_accept), 0);
        do_tick(1'b1, 1'b0);
        do_write(ETX);
        chk("R9", "ETX accepted after window", int'(cmd_accept), 1);
        chk("R7", "ta cleared", int'(ta), 0);
        do_tick(1'b1, 1'b0);
        do_tick(1'b1, 1'b0);
    endtask

    task automatic t_release_at_end();
        fix_en = 1'b1;
        @(negedge clk);
        ri_set = 1'b1;
        @(negedge clk);
        chk("R10", "ri low during pulse", int'(ri), 0);
        @(negedge clk);
        chk("R10", "ri still low", int'(ri), 0);
        ri_set = 1'b0;
        @(negedge clk);
        chk("R10", "ri high after pulse end", int'(ri), 1);
        do_write(ERX);
        chk("R10", "ERX accepted at once", int'(cmd_accept), 1);
        chk("R7", "ri cleared", int'(ri), 0);
    endtask

    initial begin
        t_reset();
        t_pace_node();
        t_pace_xtal();
        t_clear_flags();
        t_window();
        t_release_at_end();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule